// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction word into the control lines that steer a single-cycle datapath. These lines are the write-register selector, the second-operand source, the result source, the register-file write enable, the data-memory read and write strobes, the branch and jump flags, and a 3-bit ALU operation code. It is purely combinational. Its outputs settle in the same cycle as the instruction fields that drive them.

Decoding happens in two steps. A main decoder looks at the opcode and picks a 2-bit ALU class: add, subtract, or "consult the function field". A second step resolves that class into the 3-bit operation. The only opcodes decoded are register-register arithmetic, load word, store word, branch-if-equal and jump. Any other opcode, and any unknown function code under the register-register opcode, leaves the machine state untouched. Outputs that do not matter for an instruction are driven low, so they never show X.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Opcode 6'b000000 with a known function code drives reg_dst=1, alu_src=0, mem_to_reg=0, reg_wr=1, mem_rd=0, mem_wr=0, branch=0, jump=0.
- R2: Opcode 6'b100011 (load) drives reg_dst=0, alu_src=1, mem_to_reg=1, reg_wr=1, mem_rd=1, mem_wr=0, branch=0, jump=0, alu_op=3'b100.
- R3: Opcode 6'b101011 (store) drives alu_src=1, mem_wr=1, alu_op=3'b100, with reg_dst, mem_to_reg, reg_wr, mem_rd, branch and jump all 0.
- R4: Opcode 6'b000100 (branch-if-equal) drives branch=1, alu_op=3'b101 (subtract), with every other control line 0.
- R5: Opcode 6'b000010 (jump) drives jump=1, alu_op=3'b100, with every other control line 0.
- R6: The ALU operation code is 3 bits: and=000, or=010, add=100, subtract=101, set-less-than=111.
- R7: Under opcode 6'b000000, the function code selects alu_op as follows: 6'b100000 gives 100, 6'b100010 gives 101, 6'b100100 gives 000, 6'b100101 gives 010, and 6'b101010 gives 111.
- R8: Any opcode outside the five listed drives every control line to 0 and alu_op to 3'b100.
- R9: Opcode 6'b000000 with an unknown function code drives reg_wr=0, reg_dst=1, alu_op=3'b100, and every other control line 0.
- R10: At most one of mem_rd, mem_wr, branch and jump is high at any time, and reg_wr is never high together with mem_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31..26 |
| funct | input | 6 | Instruction bits 5..0 |
| reg_dst | output | 1 | 1: write register taken from the rd field; 0: taken from the rt field |
| alu_src | output | 1 | 1: second ALU operand is the extended immediate |
| mem_to_reg | output | 1 | 1: register write data comes from data memory |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| branch | output | 1 | Conditional branch; the datapath ANDs it with the ALU zero flag |
| jump | output | 1 | Unconditional jump |
| alu_op | output | 3 | ALU operation code |

## Verification
Immediate assertions inside the decoder check, whenever an input changes, the invariants that hold across all instructions. These are the exclusivity of the memory, branch and jump strobes, no register write together with a store, load/store/branch ALU codes, and silence on unlisted opcodes. The exact values per instruction can only be shown by the bench's scenarios. These are each function code's mapping, the zeroed don't-care lines, and an unknown function code suppressing the register write. The bench also sweeps every opcode value to show that unlisted ones stay inert.

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder #(
  parameter int OPW = 6,
  parameter int FNW = 6
) (
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] funct,
  output logic           reg_dst,
  output logic           alu_src,
  output logic           mem_to_reg,
  output logic           reg_wr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           branch,
  output logic           jump,
  output logic [2:0]     alu_op
);
  localparam logic [OPW-1:0] OP_REG  = OPW'(6'b000000);
  localparam logic [OPW-1:0] OP_LOAD = OPW'(6'b100011);
  localparam logic [OPW-1:0] OP_STOR = OPW'(6'b101011);
  localparam logic [OPW-1:0] OP_BREQ = OPW'(6'b000100);
  localparam logic [OPW-1:0] OP_JUMP = OPW'(6'b000010);

  localparam logic [FNW-1:0] FN_ADD = FNW'(6'b100000);
  localparam logic [FNW-1:0] FN_SUB = FNW'(6'b100010);
  localparam logic [FNW-1:0] FN_AND = FNW'(6'b100100);
  localparam logic [FNW-1:0] FN_OR  = FNW'(6'b100101);
  localparam logic [FNW-1:0] FN_SLT = FNW'(6'b101010);

  localparam logic [2:0] A_AND = 3'b000;
  localparam logic [2:0] A_OR  = 3'b010;
  localparam logic [2:0] A_ADD = 3'b100;
  localparam logic [2:0] A_SUB = 3'b101;
  localparam logic [2:0] A_SLT = 3'b111;

  typedef enum logic [1:0] {CLS_ADD = 2'b00, CLS_SUB = 2'b01, CLS_FN = 2'b10} alu_cls_e;

  alu_cls_e cls;
  logic     main_wr;
  logic     fn_ok;

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    main_wr    = 1'b0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    cls        = CLS_ADD;
    case (opcode)
      OP_REG:  begin reg_dst = 1'b1; main_wr = 1'b1; cls = CLS_FN; end
      OP_LOAD: begin alu_src = 1'b1; mem_to_reg = 1'b1; main_wr = 1'b1; mem_rd = 1'b1; end
      OP_STOR: begin alu_src = 1'b1; mem_wr = 1'b1; end
      OP_BREQ: begin branch = 1'b1; cls = CLS_SUB; end
      OP_JUMP: jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    fn_ok  = 1'b1;
    alu_op = A_ADD;
    case (cls)
      CLS_SUB: alu_op = A_SUB;
      CLS_FN: begin
        case (funct)
          FN_ADD:  alu_op = A_ADD;
          FN_SUB:  alu_op = A_SUB;
          FN_AND:  alu_op = A_AND;
          FN_OR:   alu_op = A_OR;
          FN_SLT:  alu_op = A_SLT;
          default: fn_ok  = 1'b0;
        endcase
      end
      default: alu_op = A_ADD;
    endcase
  end

  assign reg_wr = main_wr & fn_ok;

  always_comb begin
    // R10
    strobe_excl_chk: assert ($countones({mem_rd, mem_wr, branch, jump}) <= 1)
      else $error("strobes not exclusive");
    // R10
    wr_conflict_chk: assert (!(reg_wr && mem_wr)) else $error("reg write with store");
    // R3
    store_path_chk: assert (!mem_wr || (alu_src && alu_op == A_ADD)) else $error("store path");
    // R4
    branch_sub_chk: assert (!branch || alu_op == A_SUB) else $error("branch not subtract");
    // R2
    load_path_chk: assert (!mem_rd || (mem_to_reg && reg_wr && alu_op == A_ADD))
      else $error("load path");
    // R8
    unlisted_quiet_chk: assert (opcode == OP_REG || opcode == OP_LOAD || opcode == OP_STOR ||
                                opcode == OP_BREQ || opcode == OP_JUMP ||
                                !(reg_wr || mem_rd || mem_wr || branch || jump || reg_dst))
      else $error("unlisted opcode not inert");
  end
endmodule

// File: tb/instr_ctrl_decoder_test.sv
module instr_ctrl_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0] opcode = 6'h3F;
  logic [5:0] funct  = 6'h00;
  logic reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump;
  logic [2:0] alu_op;

  instr_ctrl_decoder uut (
    .opcode(opcode), .funct(funct), .reg_dst(reg_dst), .alu_src(alu_src),
    .mem_to_reg(mem_to_reg), .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .branch(branch), .jump(jump), .alu_op(alu_op)
  );

  // packing: {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_op}
  logic [10:0] exp_q[$];
  string       tag_q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam logic [10:0] E_INERT = 11'b0000_0000_100;

  task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                       input logic [10:0] exp, input string tag);
    @(posedge clk);
    #1;
    opcode = op;
    funct  = fn;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      logic [10:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_op};
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s op=%b fn=%b actual=%b expected=%b", t, opcode, funct, a, e);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compared++;
    if ({reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_op} !== E_INERT) begin
      mismatched++;
      $display("FAIL reset R8 actual=%b expected=%b",
               {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_op}, E_INERT);
    end
    rst = 1'b0;

    // R1 R7 R6: register-register with each known function code
    drive(6'b000000, 6'b100000, 11'b1001_0000_100, "R1_R7_add");
    drive(6'b000000, 6'b100010, 11'b1001_0000_101, "R1_R7_sub");
    drive(6'b000000, 6'b100100, 11'b1001_0000_000, "R1_R7_and");
    drive(6'b000000, 6'b100101, 11'b1001_0000_010, "R1_R7_or");
    drive(6'b000000, 6'b101010, 11'b1001_0000_111, "R1_R7_slt");
    // R2: load, funct ignored
    drive(6'b100011, 6'b000000, 11'b0111_1000_100, "R2_load");
    drive(6'b100011, 6'b100010, 11'b0111_1000_100, "R2_load_fn");
    // R3
    drive(6'b101011, 6'b101010, 11'b0100_0100_100, "R3_store");
    // R4
    drive(6'b000100, 6'b100100, 11'b0000_0010_101, "R4_beq");
    // R5
    drive(6'b000010, 6'b100010, 11'b0000_0001_100, "R5_jump");
    // R9: unknown function codes
    drive(6'b000000, 6'b000000, 11'b1000_0000_100, "R9_fn00");
    drive(6'b000000, 6'b100001, 11'b1000_0000_100, "R9_fn21");
    drive(6'b000000, 6'b111111, 11'b1000_0000_100, "R9_fn3f");
    // R8: sweep of all unlisted opcodes, R10 exclusivity also watched
    for (int o = 0; o < 64; o++) begin
      logic [5:0] ov;
      ov = 6'(o);
      if (ov != 6'b000000 && ov != 6'b100011 && ov != 6'b101011 &&
          ov != 6'b000100 && ov != 6'b000010)
        drive(ov, 6'(o ^ 6'h2A), E_INERT, "R8_unlisted");
    end
    // R10: back-to-back store then load then branch
    drive(6'b101011, 6'b0, 11'b0100_0100_100, "R10_store");
    drive(6'b100011, 6'b0, 11'b0111_1000_100, "R10_load");
    drive(6'b000100, 6'b0, 11'b0000_0010_101, "R10_beq");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule